// File: doc/BRIEF.md
# Window comparison sequencer for a serial threshold comparator

This block runs on the host side of a link to a serial-programmed threshold comparator. It classifies one analog input against a window in one call. A single-cycle `go` captures an upper limit, a lower limit, a channel-selection word and a half-period setting for the serial clock. The block then runs two complete programming frames, one per limit. It reads back one decision bit after each frame and reports whether the input lies above the window, below it or inside it.

Each frame opens with chip select falling and DI already holding the first bit. Twelve rising serial clock edges then carry a start bit, the selection word and the limit. The block skips the comparator's undefined-output interval and samples one settled decision. It then raises chip select, which clears the comparator before the second frame starts. The serial clock is derived from the system clock with equal high and low phases, so the duty cycle stays at 50% for any divider setting.

Top module: `wcmp_seq`

## Requirements
- R1: After reset `ser_cs_n` is 1, `ser_clk` is 0, `ser_di` is 0, `busy` and `done` are 0, and `verdict` is 2'b00 (no result yet).
- R2: In every frame the comparator sees 12 rising edges of `ser_clk` while `ser_cs_n` is low. DI on those edges is, in order: a 1 start bit on the first edge, then `mux_sel` most significant bit first, then the limit least significant bit first.
- R3: `ser_di` never changes in a cycle where `ser_clk` rises. The first bit of a frame is on DI when `ser_cs_n` falls, one full half period before the first rising edge.
- R4: Every high phase of `ser_clk`, and every low phase between two rising edges, lasts max(`half_div`,1) system cycles, using the value captured at `go`.
- R5: The first frame carries `upper_lim` and the second carries `lower_lim`. Between them `ser_cs_n` is high for exactly two half periods. At the end of the sequence it is left high.
- R6: The decision of a frame is taken on the 14th rising edge of that frame, the second rising edge after the edge that completes programming. The value driven during the undefined interval is never used.
- R7: `verdict` is 2'b11 when both decisions are 1 (above), 2'b01 when both are 0 (below), and 2'b10 when they differ (inside).
- R8: `done` is a one-cycle pulse. `verdict` changes only in that cycle and is held until the next pulse. `busy` is high from the cycle after an accepted `go` until `done`, and is low while `done` is high.
- R9: `go`, and any change on the limit, selection or divider inputs, have no effect while `busy` is high.
- R10: `ser_clk` is low whenever `ser_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, accepted only while idle |
| upper_lim | input | 8 | Upper window limit (first frame) |
| lower_lim | input | 8 | Lower window limit (second frame) |
| mux_sel | input | 3 | Channel-selection word sent after the start bit |
| half_div | input | DIV_W | System cycles per serial clock half period (0 treated as 1) |
| ser_cs_n | output | 1 | Chip select to the comparator, active low |
| ser_clk | output | 1 | Serial clock to the comparator |
| ser_di | output | 1 | Serial data to the comparator |
| ser_do | input | 1 | Decision bit from the comparator |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| verdict | output | 2 | 01 below, 10 inside, 11 above, 00 none yet |

## Verification
Several rules are checked on every cycle:
- DI stays still when the serial clock rises.
- The serial clock stays low while chip select is high.
- `done` lasts one cycle and never overlaps `busy`.
- `verdict` stays unchanged outside the `done` cycle, and a running sequence cannot be cut short.

Other behaviours need the bench's comparator model:
- the bit order of each frame;
- the setup and gap lengths and the phase lengths;
- sampling after the undefined interval, since the model drives the inverted answer there;
- the three-way verdict across inputs on and next to both limits.

// File: rtl/wcmp_pkg.sv
package wcmp_pkg;

    localparam int LIM_W       = 8;
    localparam int MUX_W       = 3;
    localparam int FRAME_BITS  = 1 + MUX_W + LIM_W;
    localparam int SAMPLE_RISE = FRAME_BITS + 2;
    localparam int GAP_HALVES  = 2;
    localparam int RISE_W      = $clog2(SAMPLE_RISE + 1);
    localparam int GAP_W       = $clog2(GAP_HALVES + 1);

    typedef enum logic [1:0] {
        VERD_NONE   = 2'b00,
        VERD_BELOW  = 2'b01,
        VERD_INSIDE = 2'b10,
        VERD_ABOVE  = 2'b11
    } verdict_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_FRAME,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic [LIM_W-1:0] lower;
        logic [MUX_W-1:0] mux;
    } job_t;

    // Bit 0 of the result is the first bit placed on the serial line.
    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic [MUX_W-1:0] mux,
        input logic [LIM_W-1:0] lim
    );
        logic [FRAME_BITS-1:0] f;
        f    = '0;
        f[0] = 1'b1;
        for (int i = 0; i < MUX_W; i++) begin
            f[1 + i] = mux[MUX_W - 1 - i];
        end
        for (int i = 0; i < LIM_W; i++) begin
            f[1 + MUX_W + i] = lim[i];
        end
        return f;
    endfunction

    function automatic verdict_e classify(input logic hi, input logic lo);
        if (hi && lo) begin
            return VERD_ABOVE;
        end
        if (!hi && !lo) begin
            return VERD_BELOW;
        end
        return VERD_INSIDE;
    endfunction

endpackage

// File: rtl/wcmp_halftick.sv
module wcmp_halftick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    assign last = (half_div == '0) ? '0 : half_div - DIV_W'(1);
    assign tick = run && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/wcmp_frame_shift.sv
module wcmp_frame_shift #(
    parameter int BITS = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [BITS-1:0] frame,
    input  logic            shift,
    output logic            di
);
    logic [BITS-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= frame;
        end else if (shift) begin
            sreg <= {1'b0, sreg[BITS-1:1]};
        end
    end

    assign di = sreg[0];
endmodule

// File: rtl/wcmp_result.sv
module wcmp_result
    import wcmp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sample,
    input  logic     second,
    input  logic     do_bit,
    input  logic     finish,
    output verdict_e verdict,
    output logic     done
);
    logic hi_q;
    logic lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q    <= 1'b0;
            lo_q    <= 1'b0;
            verdict <= VERD_NONE;
            done    <= 1'b0;
        end else begin
            if (sample) begin
                if (second) begin
                    lo_q <= do_bit;
                end else begin
                    hi_q <= do_bit;
                end
            end
            done <= finish;
            if (finish) begin
                verdict <= classify(hi_q, lo_q);
            end
        end
    end
endmodule

// File: rtl/wcmp_seq.sv
module wcmp_seq
    import wcmp_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [LIM_W-1:0] upper_lim,
    input  logic [LIM_W-1:0] lower_lim,
    input  logic [MUX_W-1:0] mux_sel,
    input  logic [DIV_W-1:0] half_div,
    output logic             ser_cs_n,
    output logic             ser_clk,
    output logic             ser_di,
    input  logic             ser_do,
    output logic             busy,
    output logic             done,
    output logic [1:0]       verdict
);
    seq_state_e            state;
    job_t                  job;
    logic [DIV_W-1:0]      div_q;
    logic                  clk_q;
    logic                  cs_q;
    logic [RISE_W-1:0]     rise_cnt;
    logic                  frame_sel;
    logic [GAP_W-1:0]      gap_cnt;

    logic                  tick;
    logic                  load_frame;
    logic                  shift_di;
    logic                  sample_stb;
    logic                  finish_stb;
    logic [FRAME_BITS-1:0] frame_word;
    verdict_e              res_verdict;

    wcmp_halftick #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .run      (state != ST_IDLE),
        .half_div (div_q),
        .tick     (tick)
    );

    wcmp_frame_shift #(.BITS(FRAME_BITS)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (load_frame),
        .frame (frame_word),
        .shift (shift_di),
        .di    (ser_di)
    );

    wcmp_result u_result (
        .clk     (clk),
        .rst     (rst),
        .sample  (sample_stb),
        .second  (frame_sel),
        .do_bit  (ser_do),
        .finish  (finish_stb),
        .verdict (res_verdict),
        .done    (done)
    );

    always_comb begin
        load_frame = 1'b0;
        shift_di   = 1'b0;
        sample_stb = 1'b0;
        finish_stb = 1'b0;
        frame_word = build_frame(job.mux, job.lower);
        unique case (state)
            ST_IDLE: begin
                if (go) begin
                    load_frame = 1'b1;
                    frame_word = build_frame(mux_sel, upper_lim);
                end
            end
            ST_FRAME: begin
                if (tick) begin
                    if (!clk_q) begin
                        sample_stb = (rise_cnt == RISE_W'(SAMPLE_RISE - 1));
                    end else begin
                        shift_di = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tick && gap_cnt == GAP_W'(GAP_HALVES - 1)) begin
                    if (!frame_sel) begin
                        load_frame = 1'b1;
                    end else begin
                        finish_stb = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            job       <= '0;
            div_q     <= '0;
            clk_q     <= 1'b0;
            cs_q      <= 1'b1;
            rise_cnt  <= '0;
            frame_sel <= 1'b0;
            gap_cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        job.lower <= lower_lim;
                        job.mux   <= mux_sel;
                        div_q     <= half_div;
                        cs_q      <= 1'b0;
                        frame_sel <= 1'b0;
                        state     <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (tick) begin
                        clk_q    <= 1'b1;
                        rise_cnt <= RISE_W'(1);
                        state    <= ST_FRAME;
                    end
                end
                ST_FRAME: begin
                    if (tick) begin
                        if (!clk_q) begin
                            clk_q    <= 1'b1;
                            rise_cnt <= rise_cnt + RISE_W'(1);
                        end else begin
                            clk_q <= 1'b0;
                            if (rise_cnt == RISE_W'(SAMPLE_RISE)) begin
                                cs_q    <= 1'b1;
                                gap_cnt <= '0;
                                state   <= ST_GAP;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_cnt == GAP_W'(GAP_HALVES - 1)) begin
                            if (!frame_sel) begin
                                cs_q      <= 1'b0;
                                frame_sel <= 1'b1;
                                state     <= ST_SETUP;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            gap_cnt <= gap_cnt + GAP_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ser_cs_n = cs_q;
    assign ser_clk  = clk_q;
    assign busy     = (state != ST_IDLE);
    assign verdict  = res_verdict;
endmodule

// File: rtl/wcmp_seq_chk.sv
module wcmp_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       go,
    input logic       ser_cs_n,
    input logic       ser_clk,
    input logic       ser_di,
    input logic       busy,
    input logic       done,
    input logic [1:0] verdict
);
    assert_di_still_at_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk) |-> $stable(ser_di));

    assert_clk_low_when_deselected_R10: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> !ser_cs_n);

    assert_done_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_verdict_held_R8: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(verdict));

    assert_verdict_defined_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (verdict != 2'b00));

    assert_go_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && go) |=> (busy || done));
endmodule

bind wcmp_seq wcmp_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .ser_cs_n (ser_cs_n),
    .ser_clk  (ser_clk),
    .ser_di   (ser_di),
    .busy     (busy),
    .done     (done),
    .verdict  (verdict)
);

// File: tb/wcmp_seq_bench.sv
module wcmp_seq_bench;
    localparam int DIV_W = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst = 1'b1;
    logic             go = 1'b0;
    logic [7:0]       upper_lim = '0;
    logic [7:0]       lower_lim = '0;
    logic [2:0]       mux_sel = '0;
    logic [DIV_W-1:0] half_div = '0;
    logic             ser_cs_n;
    logic             ser_clk;
    logic             ser_di;
    logic             ser_do = 1'b0;
    logic             busy;
    logic             done;
    logic [1:0]       verdict;

    wcmp_seq #(.DIV_W(DIV_W)) u_wcmp_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .upper_lim (upper_lim),
        .lower_lim (lower_lim),
        .mux_sel   (mux_sel),
        .half_div  (half_div),
        .ser_cs_n  (ser_cs_n),
        .ser_clk   (ser_clk),
        .ser_di    (ser_di),
        .ser_do    (ser_do),
        .busy      (busy),
        .done      (done),
        .verdict   (verdict)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural comparator: programs on rising edges, answers on falling edges,
    // and drives the wrong answer during its undefined interval.
    int         vin = 0;
    logic       m_prev_clk = 1'b0;
    logic       m_started = 1'b0;
    logic       m_prog = 1'b0;
    int         m_cnt = 0;
    int         m_negs = 0;
    int         m_rises = 0;
    logic [2:0] m_mux = '0;
    logic [7:0] m_code = '0;
    int         log_n = 0;
    logic [7:0] log_code [2];
    logic [2:0] log_mux [2];
    int         log_start [2];

    always @(negedge clk) begin
        if (ser_cs_n) begin
            m_started = 1'b0;
            m_prog    = 1'b0;
            m_cnt     = 0;
            m_negs    = 0;
            m_rises   = 0;
        end else if (ser_clk && !m_prev_clk) begin
            m_rises++;
            if (!m_prog) begin
                if (!m_started) begin
                    if (ser_di) begin
                        m_started = 1'b1;
                        m_cnt     = 0;
                        if (log_n < 2) log_start[log_n] = m_rises;
                    end
                end else begin
                    if (m_cnt < 3) m_mux = {m_mux[1:0], ser_di};
                    else m_code[m_cnt-3] = ser_di;
                    m_cnt++;
                    if (m_cnt == 11) begin
                        m_prog = 1'b1;
                        m_negs = 0;
                        if (log_n < 2) begin
                            log_code[log_n] = m_code;
                            log_mux[log_n]  = m_mux;
                        end
                        log_n++;
                    end
                end
            end
        end else if (!ser_clk && m_prev_clk && m_prog) begin
            m_negs++;
            ser_do = (m_negs == 1) ? !(vin > int'(m_code)) : (vin > int'(m_code));
        end
        m_prev_clk = ser_clk;
    end

    // Phase, setup and gap measurement at the pins.
    int   eff_now = 1;
    int   seg_len = 0;
    logic seg_from_cs = 1'b0;
    int   phase_err = 0;
    int   setup_len = 0;
    int   gap_len = 0;
    int   cs_hi_cnt = 0;
    logic p_clk = 1'b0;
    logic p_cs = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (ser_clk && ser_cs_n) phase_err++;
            if (ser_clk != p_clk) begin
                if (p_clk) begin
                    if (seg_len != eff_now) phase_err++;
                end else if (seg_from_cs) begin
                    setup_len = seg_len;
                end else if (seg_len != eff_now) begin
                    phase_err++;
                end
                seg_len     = 1;
                seg_from_cs = 1'b0;
            end else if (!ser_cs_n && p_cs) begin
                gap_len     = cs_hi_cnt;
                seg_len     = 1;
                seg_from_cs = 1'b1;
            end else begin
                seg_len++;
            end
            cs_hi_cnt = ser_cs_n ? cs_hi_cnt + 1 : 0;
            p_clk     = ser_clk;
            p_cs      = ser_cs_n;
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic run_seq(input int u, input int l, input int mx, input int hd,
                           input int v, input bit poke);
        int  n;
        bit  hi;
        bit  lo;
        int  exp_v;
        @(negedge clk);
        upper_lim = 8'(u);
        lower_lim = 8'(l);
        mux_sel   = 3'(mx);
        half_div  = DIV_W'(hd);
        vin       = v;
        eff_now   = (hd == 0) ? 1 : hd;
        log_n     = 0;
        phase_err = 0;
        go        = 1'b1;
        @(negedge clk);
        go = 1'b0;
        check(busy == 1'b1, "R8 busy after go", int'(busy), 1);
        if (poke) begin
            repeat (20) @(negedge clk);
            upper_lim = ~8'(u);
            lower_lim = ~8'(l);
            mux_sel   = ~3'(mx);
            half_div  = DIV_W'(hd + 3);
            go        = 1'b1;
            @(negedge clk);
            go = 1'b0;
        end
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(n < 20000, "R8 sequence completes", n, 0);
        hi    = (v > u);
        lo    = (v > l);
        exp_v = (hi && lo) ? 3 : ((!hi && !lo) ? 1 : 2);
        check(int'(verdict) == exp_v, "R7 R6 verdict", int'(verdict), exp_v);
        check(log_n == 2, "R5 frame count", log_n, 2);
        check(int'(log_code[0]) == u, "R5 R2 first frame limit", int'(log_code[0]), u);
        check(int'(log_code[1]) == l, "R5 R2 second frame limit", int'(log_code[1]), l);
        check(int'(log_mux[0]) == mx && int'(log_mux[1]) == mx, "R2 mux word",
              int'(log_mux[1]), mx);
        check(log_start[0] == 1 && log_start[1] == 1, "R2 start bit on first edge",
              log_start[1], 1);
        check(phase_err == 0, "R4 R10 phase lengths", phase_err, 0);
        check(setup_len == eff_now, "R3 DI setup before first edge", setup_len, eff_now);
        check(gap_len == 2 * eff_now, "R5 chip-select gap", gap_len, 2 * eff_now);
        check(busy == 1'b0 && ser_cs_n == 1'b1, "R8 R5 idle at done", int'(busy), 0);
        @(negedge clk);
        check(done == 1'b0, "R8 done single pulse", int'(done), 0);
        check(int'(verdict) == exp_v, "R8 verdict held", int'(verdict), exp_v);
        if (poke) begin
            repeat (40) @(negedge clk);
            check(log_n == 2 && ser_cs_n == 1'b1, "R9 no extra sequence", log_n, 2);
            check(int'(verdict) == exp_v, "R9 verdict unchanged", int'(verdict), exp_v);
        end
    endtask

    int wu [5] = '{200, 128, 255, 10, 60};
    int wl [5] = '{60, 127, 0, 10, 200};

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ser_cs_n == 1'b1 && ser_clk == 1'b0 && ser_di == 1'b0, "R1 serial pins idle",
              int'({ser_cs_n, ser_clk, ser_di}), 4);
        check(busy == 1'b0 && done == 1'b0 && verdict == 2'b00, "R1 status idle",
              int'({busy, done, verdict}), 0);

        for (int w = 0; w < 5; w++) begin
            for (int k = 0; k < 8; k++) begin
                int pts [8];
                int v;
                pts = '{0, 255, wl[w] - 1, wl[w], wl[w] + 1, wu[w] - 1, wu[w], wu[w] + 1};
                v = pts[k];
                if (v < 0) v = 0;
                if (v > 255) v = 255;
                run_seq(wu[w], wl[w], k, (w + k) % 4, v, 1'b0);
            end
        end

        for (int v = 0; v < 256; v += 15) begin
            run_seq(180, 70, v % 8, 2, v, 1'b0);
        end

        run_seq(150, 90, 5, 2, 120, 1'b1);
        run_seq(150, 90, 2, 1, 200, 1'b1);

        summary();
        $finish;
    end
endmodule